// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer-to-Binary Encoder

This block turns a sampled delay-line snapshot into a compact binary count. The snapshot is a wide thermometer word whose ones fill upward from bit 0, with zeros above. The output is the length of that run of ones. Capture flip-flops in the line can disagree on setup time, which leaves stray ones above the real edge. The block rejects them.

The boundary is located by looking for a zero sitting directly above two ones, not for a single zero-to-one step. A single one with zeros on both sides is treated as a capture fault and skipped. When several candidate boundaries exist, the highest one wins. The encoder is fully synchronous and pipelined in three register stages. It accepts one word per clock, and each result appears a fixed three cycles after its input strobe.

Top module: `bubble_therm_encoder`

## Requirements
- R1: For a clean word made of n ones in bits 0..n-1 and zeros above (0 <= n <= 128), out_code equals n.
- R2: A one at bit p with zeros at bits p-1 and p+1 (p >= 1) has no effect on out_code.
- R3: out_code equals i+1 for the highest i where bit i+1 is 0, bit i is 1 and bit i-1 is 1. A virtual 0 above bit 127 and a virtual 1 below bit 0 apply. So a pair of ones above a gap outranks a lower edge, and the word with bits 0..6 and 8 set encodes to 7.
- R4: An all-ones word encodes to 128, and out_code never exceeds 128 in its 8-bit field.
- R5: An all-zero word encodes to 0 with out_error low.
- R6: A word with bit 0 set and bit 1 clear, and no qualifying boundary higher up, encodes to 1.
- R7: A nonzero word with no qualifying boundary (only possible with bit 0 clear) encodes to 0 with out_error high.
- R8: out_valid is high exactly 3 clock cycles after each in_valid and low otherwise. A new word can be accepted every cycle.
- R9: While rst is high and in the first cycle after it falls, out_valid and out_error are low. out_error is never high without out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe qualifying in_word this cycle |
| in_word | input | 128 | Sampled thermometer snapshot, ones from bit 0 |
| out_valid | output | 1 | Result strobe, 3 cycles after in_valid |
| out_code | output | 8 | Number of ones in the low run |
| out_error | output | 1 | No boundary found in a nonzero word |

## Verification
The bench aims at words where a naive highest-set-bit encoder goes wrong. A bubble just above the edge would make such an encoder report a code two or more too high. A pair of ones above a gap tells whether the design honours the highest-boundary rule or stops at the lowest edge. The extremes matter as well. An all-ones word catches a design that drops the virtual zero above the top bit or wraps the 8-bit code. A lone bit 0 catches one that drops the virtual one below bit 0, and such a design would report 0 or flag an error. Back-to-back strobes with random gaps expose a pipeline that slips a cycle or mixes results from neighbouring words.

// File: rtl/bte_pkg.sv
package bte_pkg;
  // Width of a count that must represent 0..w inclusive.
  function automatic int code_width(input int w);
    return $clog2(w + 1);
  endfunction

  // Index width for a segment of a given size.
  function automatic int index_width(input int w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction
endpackage

// File: rtl/therm_edge_scan.sv
// Stage 1: mark every position that sits just below a 0 and has a 1 under it.
module therm_edge_scan #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         scan_valid,
  output logic [W-1:0] scan_match,
  output logic         scan_nonzero
);
  localparam int EXT_W = W + 2;

  logic [EXT_W-1:0] ext_word;
  logic [W-1:0]     match_c;

  // Virtual 0 above the top tap, virtual 1 under bit 0.
  assign ext_word = {1'b0, in_word, 1'b1};

  generate
    for (genvar i = 0; i < W; i++) begin : g_tap
      assign match_c[i] = ~ext_word[i+2] & ext_word[i+1] & ext_word[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_valid <= 1'b0;
    end else begin
      scan_valid <= in_valid;
    end
    scan_match   <= match_c;
    scan_nonzero <= |in_word;
  end
endmodule

// File: rtl/therm_seg_prio.sv
// Stage 2: highest marked position inside one segment.
module therm_seg_prio #(
  parameter int SEG_W = 16,
  parameter int IDX_W = bte_pkg::index_width(SEG_W)
) (
  input  logic             clk,
  input  logic [SEG_W-1:0] seg_match,
  output logic             seg_hit,
  output logic [IDX_W-1:0] seg_idx
);
  logic [IDX_W-1:0] idx_c;

  always_comb begin
    idx_c = '0;
    for (int i = 0; i < SEG_W; i++) begin
      if (seg_match[i]) idx_c = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    seg_hit <= |seg_match;
    seg_idx <= idx_c;
  end
endmodule

// File: rtl/therm_seg_merge.sv
// Stage 3: pick the highest segment with a hit and form the final count.
module therm_seg_merge #(
  parameter int NSEG   = 8,
  parameter int SEG_W  = 16,
  parameter int IDX_W  = bte_pkg::index_width(SEG_W),
  parameter int CODE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mrg_valid,
  input  logic                  mrg_nonzero,
  input  logic [NSEG-1:0]       mrg_hit,
  input  logic [NSEG*IDX_W-1:0] mrg_idx,
  output logic                  out_valid,
  output logic [CODE_W-1:0]     out_code,
  output logic                  out_error
);
  logic              found_c;
  logic [CODE_W-1:0] code_c;

  always_comb begin
    found_c = 1'b0;
    code_c  = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (mrg_hit[s]) begin
        found_c = 1'b1;
        code_c  = CODE_W'(s * SEG_W) + CODE_W'(mrg_idx[s*IDX_W +: IDX_W]) + CODE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_error <= 1'b0;
    end else begin
      out_valid <= mrg_valid;
      out_error <= mrg_valid & ~found_c & mrg_nonzero;
    end
    if (mrg_valid) begin
      out_code <= found_c ? code_c : '0;
    end
  end
endmodule

// File: rtl/bubble_therm_encoder.sv
module bubble_therm_encoder #(
  parameter int W      = 128,
  parameter int SEG_W  = 16,
  parameter int CODE_W = bte_pkg::code_width(W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [W-1:0]      in_word,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic              out_error
);
  localparam int NSEG  = W / SEG_W;
  localparam int IDX_W = bte_pkg::index_width(SEG_W);

  logic                  s1_valid;
  logic [W-1:0]          s1_match;
  logic                  s1_nonzero;
  logic                  s2_valid;
  logic                  s2_nonzero;
  logic [NSEG-1:0]       s2_hit;
  logic [NSEG*IDX_W-1:0] s2_idx;

  therm_edge_scan #(.W(W)) u_scan (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_word      (in_word),
    .scan_valid   (s1_valid),
    .scan_match   (s1_match),
    .scan_nonzero (s1_nonzero)
  );

  generate
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
      therm_seg_prio #(.SEG_W(SEG_W), .IDX_W(IDX_W)) u_prio (
        .clk       (clk),
        .seg_match (s1_match[s*SEG_W +: SEG_W]),
        .seg_hit   (s2_hit[s]),
        .seg_idx   (s2_idx[s*IDX_W +: IDX_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
    end
    s2_nonzero <= s1_nonzero;
  end

  therm_seg_merge #(
    .NSEG(NSEG), .SEG_W(SEG_W), .IDX_W(IDX_W), .CODE_W(CODE_W)
  ) u_merge (
    .clk         (clk),
    .rst         (rst),
    .mrg_valid   (s2_valid),
    .mrg_nonzero (s2_nonzero),
    .mrg_hit     (s2_hit),
    .mrg_idx     (s2_idx),
    .out_valid   (out_valid),
    .out_code    (out_code),
    .out_error   (out_error)
  );
endmodule

// File: rtl/bubble_therm_encoder_chk.sv
module bubble_therm_encoder_chk #(
  parameter int W      = 128,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [W-1:0]      in_word,
  input logic              out_valid,
  input logic [CODE_W-1:0] out_code,
  input logic              out_error
);
  logic [1:0] settle;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst) settle <= 2'd0;
    else if (settle != 2'd3) settle <= settle + 2'd1;
  end
  assign warm = (settle == 2'd3);

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    warm |-> (out_valid == $past(in_valid, 3)));

  p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_error) |-> (out_code == '0));

  p_err_valid_r9: assert property (@(posedge clk) disable iff (rst)
    out_error |-> out_valid);

  p_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_error));

  p_range_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_code <= CODE_W'(W)));

  p_full_r4: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(in_valid, 3) && ($past(in_word, 3) == {W{1'b1}})) |-> (out_code == CODE_W'(W)));

  p_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(in_valid, 3) && ($past(in_word, 3) == '0)) |-> (out_code == '0 && !out_error));
endmodule

bind bubble_therm_encoder bubble_therm_encoder_chk #(.W(W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/bubble_therm_encoder_bench.sv
`timescale 1ns/1ps
module bubble_therm_encoder_bench;
  localparam int W = 128;
  localparam int CODE_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [W-1:0]      in_word = '0;
  logic              out_valid;
  logic [CODE_W-1:0] out_code;
  logic              out_error;

  int checks = 0;
  int failures = 0;

  bit    h_v[3];
  int    h_code[3];
  bit    h_err[3];
  string h_tag[3];

  always #2 clk = ~clk;

  bubble_therm_encoder u_bubble_therm_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_code(out_code), .out_error(out_error)
  );

  function automatic void ref_enc(input logic [W-1:0] w, output int code, output bit err);
    bit found = 0;
    code = 0;
    err  = 0;
    for (int i = W - 1; i >= 0; i--) begin
      bit above = (i == W - 1) ? 1'b0 : w[i+1];
      bit below = (i == 0) ? 1'b1 : w[i-1];
      if (!found && !above && w[i] && below) begin
        code = i + 1;
        found = 1;
      end
    end
    if (!found) err = (w != '0);
  endfunction

  function automatic logic [W-1:0] therm(input int n);
    logic [W-1:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One cycle: check the result due now, then drive the next word.
  task automatic step(input bit v, input logic [W-1:0] w, input string tag);
    int  c;
    bit  e;
    @(negedge clk);
    check({h_tag[2], " R8 valid"}, out_valid == h_v[2], out_valid, h_v[2]);
    if (h_v[2]) begin
      check({h_tag[2], " code"}, out_code == CODE_W'(h_code[2]), out_code, h_code[2]);
      check({h_tag[2], " error"}, out_error == h_err[2], out_error, h_err[2]);
    end else begin
      check("R9 error without valid", out_error == 1'b0, out_error, 0);
    end
    for (int k = 2; k > 0; k--) begin
      h_v[k] = h_v[k-1]; h_code[k] = h_code[k-1];
      h_err[k] = h_err[k-1]; h_tag[k] = h_tag[k-1];
    end
    ref_enc(w, c, e);
    h_v[0] = v; h_code[0] = c; h_err[0] = e; h_tag[0] = tag;
    in_valid = v;
    in_word  = w;
  endtask

  function automatic logic [W-1:0] rand_word();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 3; k++) begin h_v[k] = 0; h_code[k] = 0; h_err[k] = 0; h_tag[k] = "idle"; end
    in_valid = 1'b1;
    in_word  = '1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9 reset valid", out_valid == 1'b0, out_valid, 0);
    check("R9 reset error", out_error == 1'b0, out_error, 0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 first cycle after reset", out_valid == 1'b0, out_valid, 0);

    // Directed corners
    step(1, therm(7), "R1 clean 7");
    step(1, therm(7) | (128'd1 << 8), "R2 R3 bubble next to edge");
    step(1, '1, "R4 all ones");
    step(1, '0, "R5 all zeros");
    step(1, 128'd1, "R6 lone bit0");
    step(1, 128'd1 | (128'd1 << 5), "R6 bit0 plus bubble");
    step(1, 128'd1 << 5, "R7 bubble only");
    step(1, 128'b0110, "R7 pair above clear bit0");
    step(0, '1, "R8 no strobe");
    step(1, therm(10) | (128'd3 << 20), "R3 pair above gap");
    step(1, therm(127), "R1 clean 127");
    step(1, therm(1) | (128'd1 << 127), "R2 bubble at top");
    step(1, therm(126) | (128'd1 << 127), "R3 top bubble touching gap");
    step(0, '0, "R8 gap");
    step(1, therm(16) | (128'd1 << 17) | (128'd1 << 19), "R2 two bubbles");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 3);
      int len  = $urandom_range(0, W);
      logic [W-1:0] w = therm(len);
      bit v = ($urandom_range(0, 3) != 0);
      if (kind == 0) begin
        step(v, w, "R1 random clean");
      end else if (kind == 1) begin
        for (int b = 0; b < 3; b++) begin
          int p = $urandom_range(len + 1, W + 8);
          if (p < W && (p + 1 >= W || !w[p+1]) && !w[p-1]) w[p] = 1'b1;
        end
        step(v, w, "R2 random bubbles");
      end else if (kind == 2) begin
        step(v, rand_word() & rand_word(), "R3 random sparse");
      end else begin
        step(v, rand_word(), "R3 random dense");
      end
    end
    for (int n = 0; n < 4; n++) step(0, '0, "R8 drain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule